// File: doc/BRIEF.md
# Configurable SDLC Frame Transmitter

This block turns a stream of payload bytes into one bit-serial SDLC frame per burst. A frame starts when the host presents a byte while the transmitter is idle. The block then emits an opening flag and an optional station address byte taken from a static input. Next come an optional control byte, also from a static input, and the payload bytes fetched one at a time over a valid/ready handshake. The byte flagged with `in_last` ends the payload. An optional two-byte check sequence and a closing flag complete the frame.

Three static configuration bits shape the frame. One drops the control byte. One drops the address byte as well, but only when the control byte is also dropped. One drops the check sequence, and it combines with either of the other two. Between the flags, a zero is stuffed into the line after every run of five ones. While no frame is in progress, the line rests at one.

The serial side puts out one bit per clock. `tx_active` marks the cycles that carry frame bits. If the host fails to supply a payload byte in time, the frame is aborted. The block then discards the rest of that host frame.

Top module: `sdlc_tx`

## Requirements
- R1: After reset, `tx_active` and `in_ready` are 0. Whenever `tx_active` is 0, `tx_bit` is 1.
- R2: A frame starts only when `in_valid` is seen while idle. Its first eight bits and last eight bits are each the flag 0x7E, sent least significant bit first (0,1,1,1,1,1,1,0). All frame bits arrive on consecutive cycles with `tx_active` high.
- R3: With all format bits clear, the destuffed bytes between the flags are, in order: `station_addr`, `ctrl_byte`, the payload bytes, FCS low byte, FCS high byte. Every byte is sent least significant bit first.
- R4: With `cfg_no_ctrl`=1 and `cfg_no_addr`=0, the control byte is left out and the payload follows the address directly.
- R5: With `cfg_no_addr`=1 and `cfg_no_ctrl`=1, the payload follows the opening flag directly. `cfg_no_addr`=1 with `cfg_no_ctrl`=0 produces the standard format of R3.
- R6: With `cfg_no_fcs`=1, the two check bytes are left out and the closing flag follows the last payload byte. This works together with any setting of the other two bits.
- R7: The FCS is computed as follows. It uses the bit-reflected CRC with polynomial x^16+x^12+x^5+1, preset to 0xFFFF. It runs over the address, control and payload bytes in the order they are sent. The ones' complement of the result is sent low byte first. The payload "123456789" with no address and no control gives FCS bytes 0x6E then 0x90.
- R8: Between the flags, a 0 follows every run of five 1s, including at the end of the last byte before the closing flag. No stuffing is applied within the flags.
- R9: `in_ready` does not depend on `in_valid`. Each payload byte is taken exactly once, in a cycle where `in_valid` and `in_ready` are both 1. The payload ends with the byte taken with `in_last`=1.
- R10: Suppose `in_valid` is 0 when the next payload byte is needed. The block then sends eight unstuffed 1s and drops `tx_active`. After that, it holds `in_ready` at 1 and discards bytes without sending anything until it takes a byte with `in_last`=1. It then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_ctrl | input | 1 | Leave out the control byte |
| cfg_no_addr | input | 1 | Leave out the address byte (only with cfg_no_ctrl) |
| cfg_no_fcs | input | 1 | Leave out the check sequence |
| station_addr | input | 8 | Address byte value |
| ctrl_byte | input | 8 | Control byte value |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Block takes the host byte this cycle |
| tx_bit | output | 1 | Serial line |
| tx_active | output | 1 | Current `tx_bit` belongs to a frame |

## Verification
The hardest case to reach is a stuffed zero that must go out between the last data bit and the closing flag. A neighbouring case is a run of ones that crosses a byte boundary into the check sequence. Both need chosen bit patterns at the very end of a frame. The stimulus forces them with directed bytes such as 0xF8 ending a frame that has no FCS, and an all-ones payload. The random frames also draw payload bytes from a pool heavy in 0xFF, 0x7E and 0xF8. The abort path is reached by withdrawing `in_valid` in the middle of a frame, and the drain that follows is observed at `in_ready` and on a silent line.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
    localparam int BYTE_W     = 8;
    localparam int CRC_W      = 2 * BYTE_W;
    localparam int STUFF_RUN  = 5;
    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'hFF;
    localparam logic [CRC_W-1:0]  CRC_PRESET = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_POLY_R = 16'h8408;

    typedef enum logic [3:0] {
        FLD_IDLE, FLD_OPEN, FLD_ADDR, FLD_CTRL, FLD_INFO,
        FLD_FCS_LO, FLD_FCS_HI, FLD_CLOSE, FLD_ABORT, FLD_DRAIN
    } fld_e;

    typedef struct packed {
        fld_e fld;
        logic last;
    } seq_t;
endpackage

// File: rtl/sdlc_tx_crc.sv
module sdlc_tx_crc
    import sdlc_tx_pkg::*;
#(
    parameter int                W_BYTE = BYTE_W,
    parameter int                W_CRC  = CRC_W,
    parameter logic [W_CRC-1:0]  POLY   = CRC_POLY_R,
    parameter logic [W_CRC-1:0]  PRESET = CRC_PRESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic [W_BYTE-1:0] din,
    output logic [W_CRC-1:0]  crc
);
    logic [W_CRC-1:0] crc_d, crc_q;

    always_comb begin
        logic [W_CRC-1:0] c;
        c     = crc_q ^ {{(W_CRC-W_BYTE){1'b0}}, din};
        for (int i = 0; i < W_BYTE; i++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_d = crc_q;
        if (clear)       crc_d = PRESET;
        else if (update) crc_d = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= PRESET;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdlc_tx_ser.sv
module sdlc_tx_ser
    import sdlc_tx_pkg::*;
#(
    parameter int W_BYTE = BYTE_W,
    parameter int RUN    = STUFF_RUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [W_BYTE-1:0] load_byte,
    input  logic              load_stuff,
    output logic              need,
    output logic              bit_out,
    output logic              active
);
    localparam int CNT_W  = $clog2(W_BYTE + 1);
    localparam int ONES_W = $clog2(RUN + 1);

    typedef struct packed {
        logic [W_BYTE-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              stuf;
        logic [ONES_W-1:0] ones;
    } ser_t;

    ser_t s_d, s_q;
    logic ins;

    always_comb begin
        s_d  = s_q;
        ins  = (s_q.cnt != '0) && (s_q.ones == ONES_W'(RUN));
        need = (s_q.cnt == '0) || ((s_q.cnt == CNT_W'(1)) && !ins);
        if (s_q.cnt != '0) begin
            if (ins) begin
                s_d.ones = '0;
            end else begin
                s_d.sh   = s_q.sh >> 1;
                s_d.cnt  = s_q.cnt - CNT_W'(1);
                s_d.ones = (s_q.stuf && s_q.sh[0]) ? s_q.ones + ONES_W'(1) : '0;
            end
        end
        if (load && need) begin
            s_d.sh   = load_byte;
            s_d.cnt  = CNT_W'(W_BYTE);
            s_d.stuf = load_stuff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = (s_q.cnt != '0);
    assign bit_out = !active ? 1'b1 : (ins ? 1'b0 : s_q.sh[0]);
endmodule

// File: rtl/sdlc_tx.sv
module sdlc_tx
    import sdlc_tx_pkg::*;
#(
    parameter int W_BYTE = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_no_ctrl,
    input  logic              cfg_no_addr,
    input  logic              cfg_no_fcs,
    input  logic [W_BYTE-1:0] station_addr,
    input  logic [W_BYTE-1:0] ctrl_byte,
    input  logic              in_valid,
    input  logic [W_BYTE-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              tx_active
);
    localparam int W_CRC = 2 * W_BYTE;

    seq_t              q_d, q_q;
    logic              need, ld, ld_stuff, rdy, go_info, crc_clr, crc_upd;
    logic [W_BYTE-1:0] ld_byte;
    logic [W_CRC-1:0]  crc;
    logic              skip_addr;

    assign skip_addr = cfg_no_addr && cfg_no_ctrl;

    always_comb begin
        q_d      = q_q;
        ld       = 1'b0;
        ld_byte  = FLAG_BYTE;
        ld_stuff = 1'b0;
        rdy      = 1'b0;
        go_info  = 1'b0;
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        unique case (q_q.fld)
            FLD_IDLE: if (need && in_valid) begin
                ld = 1'b1; crc_clr = 1'b1; q_d.fld = FLD_OPEN;
            end
            FLD_OPEN: if (need) begin
                if (skip_addr) go_info = 1'b1;
                else begin
                    ld = 1'b1; ld_byte = station_addr; ld_stuff = 1'b1;
                    crc_upd = 1'b1; q_d.fld = FLD_ADDR;
                end
            end
            FLD_ADDR: if (need) begin
                if (cfg_no_ctrl) go_info = 1'b1;
                else begin
                    ld = 1'b1; ld_byte = ctrl_byte; ld_stuff = 1'b1;
                    crc_upd = 1'b1; q_d.fld = FLD_CTRL;
                end
            end
            FLD_CTRL: if (need) go_info = 1'b1;
            FLD_INFO: if (need) begin
                if (!q_q.last) go_info = 1'b1;
                else if (cfg_no_fcs) begin
                    ld = 1'b1; q_d.fld = FLD_CLOSE;
                end else begin
                    ld = 1'b1; ld_byte = ~crc[W_BYTE-1:0]; ld_stuff = 1'b1;
                    q_d.fld = FLD_FCS_LO;
                end
            end
            FLD_FCS_LO: if (need) begin
                ld = 1'b1; ld_byte = ~crc[W_CRC-1:W_BYTE]; ld_stuff = 1'b1;
                q_d.fld = FLD_FCS_HI;
            end
            FLD_FCS_HI: if (need) begin
                ld = 1'b1; q_d.fld = FLD_CLOSE;
            end
            FLD_CLOSE: if (need) q_d.fld = FLD_IDLE;
            FLD_ABORT: if (need) q_d.fld = FLD_DRAIN;
            FLD_DRAIN: begin
                rdy = 1'b1;
                if (in_valid && in_last) q_d.fld = FLD_IDLE;
            end
            default: q_d.fld = FLD_IDLE;
        endcase
        if (go_info) begin
            rdy = 1'b1;
            ld  = 1'b1;
            if (in_valid) begin
                ld_byte  = in_data;
                ld_stuff = 1'b1;
                crc_upd  = 1'b1;
                q_d.last = in_last;
                q_d.fld  = FLD_INFO;
            end else begin
                ld_byte  = ABORT_BYTE;
                q_d.fld  = FLD_ABORT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{fld: FLD_IDLE, last: 1'b0};
        else        q_q <= q_d;
    end

    assign in_ready = rdy;

    sdlc_tx_crc #(.W_BYTE(W_BYTE), .W_CRC(W_CRC)) crc_i (
        .clk(clk), .rst_n(rst_n), .clear(crc_clr), .update(crc_upd),
        .din(ld_byte), .crc(crc)
    );

    sdlc_tx_ser #(.W_BYTE(W_BYTE)) ser_i (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_byte(ld_byte),
        .load_stuff(ld_stuff), .need(need), .bit_out(tx_bit), .active(tx_active)
    );
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_bit,
    input logic tx_active
);
    logic [4:0] run_q, run_d;

    always_comb begin
        run_d = '0;
        if (tx_active && tx_bit) run_d = (run_q == 5'd31) ? run_q : run_q + 5'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> tx_bit);

    // R2
    open_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> !tx_bit);

    // R9
    pop_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tx_active) |=> tx_active);

    // R8
    ones_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> run_d <= 5'd12);
endmodule

bind sdlc_tx sdlc_tx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .tx_bit(tx_bit), .tx_active(tx_active)
);

// File: tb/sdlc_tx_tb_top.sv
`timescale 1ns/1ps
module sdlc_tx_tb_top;
    typedef logic [7:0] byte_q_t [$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_no_ctrl = 1'b0, cfg_no_addr = 1'b0, cfg_no_fcs = 1'b0;
    logic [7:0] station_addr = 8'h00, ctrl_byte = 8'h00, in_data = 8'h00;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic in_ready, tx_bit, tx_active;

    int compared = 0, mismatched = 0;
    bit rx_bits [$];
    int frames_done = 0;
    int idle_bad = 0;
    bit was_act = 1'b0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    sdlc_tx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_no_ctrl(cfg_no_ctrl), .cfg_no_addr(cfg_no_addr),
        .cfg_no_fcs(cfg_no_fcs), .station_addr(station_addr), .ctrl_byte(ctrl_byte),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit), .tx_active(tx_active)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_active) rx_bits.push_back(tx_bit);
            else begin
                if (tx_bit !== 1'b1) idle_bad++;
                if (was_act) frames_done++;
            end
            was_act = tx_active;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        compared++; mismatched++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    function automatic logic [15:0] fcs_ref(input byte_q_t q);
        logic [15:0] c = 16'hFFFF;
        foreach (q[k]) begin
            c ^= {8'h00, q[k]};
            for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build(input bit nc, input bit na, input bit nf, input logic [7:0] a,
                         input logic [7:0] c, input byte_q_t info, ref byte_q_t e);
        logic [15:0] f;
        e.delete();
        if (!(na && nc)) e.push_back(a);
        if (!nc) e.push_back(c);
        foreach (info[k]) e.push_back(info[k]);
        if (!nf) begin
            f = fcs_ref(e);
            e.push_back(f[7:0]);
            e.push_back(f[15:8]);
        end
    endtask

    function automatic logic [7:0] bits_byte(input int at);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = rx_bits[at + i];
        return v;
    endfunction

    task automatic decode(ref byte_q_t got, output bit stuff_ok, output bit whole);
        bit d [$];
        int ones = 0;
        logic [7:0] v;
        stuff_ok = 1'b1;
        got.delete();
        for (int i = 8; i < rx_bits.size() - 8; i++) begin
            if (ones == 5) begin
                if (rx_bits[i] != 1'b0) stuff_ok = 1'b0;
                ones = 0;
            end else begin
                d.push_back(rx_bits[i]);
                ones = rx_bits[i] ? ones + 1 : 0;
            end
        end
        whole = (d.size() % 8) == 0;
        for (int b = 0; b + 8 <= d.size(); b += 8) begin
            for (int i = 0; i < 8; i++) v[i] = d[b + i];
            got.push_back(v);
        end
    endtask

    task automatic drive(input byte_q_t b, input bit mark_last, output int fires);
        int i = 0;
        bit go;
        fires = 0;
        while (i < b.size()) begin
            in_data  = b[i];
            in_last  = mark_last && (i == b.size() - 1);
            in_valid = 1'b1;
            #1;
            go = in_ready;
            @(negedge clk);
            if (go) begin i++; fires++; end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_frame(input int start);
        while (frames_done == start) @(negedge clk);
    endtask

    task automatic run_frame(input bit nc, input bit na, input bit nf, input logic [7:0] a,
                             input logic [7:0] c, input byte_q_t info, input string req,
                             ref byte_q_t got);
        byte_q_t exp;
        int start, fires;
        bit sok, whole, same;
        cfg_no_ctrl = nc; cfg_no_addr = na; cfg_no_fcs = nf;
        station_addr = a; ctrl_byte = c;
        rx_bits.delete();
        start = frames_done;
        build(nc, na, nf, a, c, info, exp);
        drive(info, 1'b1, fires);
        wait_frame(start);
        check(fires == info.size(), "R9", "bytes taken", fires, info.size());
        check(rx_bits.size() >= 16 && bits_byte(0) == 8'h7E, "R2", "opening flag",
              rx_bits.size() >= 16 ? bits_byte(0) : 0, 8'h7E);
        check(rx_bits.size() >= 16 && bits_byte(rx_bits.size() - 8) == 8'h7E, "R2",
              "closing flag", rx_bits.size() >= 16 ? bits_byte(rx_bits.size() - 8) : 0, 8'h7E);
        decode(got, sok, whole);
        check(sok && whole, "R8", "zero insertion", {sok, whole}, 2'b11);
        same = (got.size() == exp.size());
        if (same) foreach (exp[k]) if (got[k] !== exp[k]) same = 1'b0;
        check(same, req, "field bytes", got.size() > 0 ? got[0] : 0, exp.size() > 0 ? exp[0] : 0);
        if (!same) $display("  length actual=%0d expected=%0d", got.size(), exp.size());
        @(negedge clk);
    endtask

    initial begin
        byte_q_t info, got;
        int start, fires;
        bit nc, na, nf;
        string req;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_active == 1'b0, "R1", "tx_active after reset", tx_active, 0);
        check(tx_bit == 1'b1, "R1", "idle line", tx_bit, 1);
        check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);

        // R3 standard format
        info = '{8'h11, 8'h22, 8'h33};
        run_frame(0, 0, 0, 8'hA5, 8'h3C, info, "R3", got);
        // R4 no control
        run_frame(1, 0, 0, 8'hC3, 8'h99, info, "R4", got);
        // R5 invalid combination behaves as standard
        run_frame(0, 1, 0, 8'h5A, 8'h0F, info, "R5", got);
        // R6 no FCS with standard header
        run_frame(0, 0, 1, 8'h01, 8'h02, info, "R6", got);

        // R7 known check value
        info = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        run_frame(1, 1, 0, 8'h00, 8'h00, info, "R5", got);
        check(got.size() == 11 && got[9] == 8'h6E && got[10] == 8'h90, "R7", "FCS bytes",
              got.size() == 11 ? {got[10], got[9]} : 0, 16'h906E);

        // R8 stuffing at end before closing flag, and all-ones payload
        info = '{8'hF8};
        run_frame(1, 1, 1, 8'h00, 8'h00, info, "R6", got);
        info = '{8'hFF, 8'hFF, 8'hFF, 8'h7E};
        run_frame(0, 0, 0, 8'hFF, 8'hFF, info, "R8", got);

        // R10 underrun abort then drain
        cfg_no_ctrl = 0; cfg_no_addr = 0; cfg_no_fcs = 0;
        rx_bits.delete();
        start = frames_done;
        info = '{8'h12, 8'h34};
        drive(info, 1'b0, fires);
        wait_frame(start);
        check(rx_bits.size() >= 16 && bits_byte(rx_bits.size() - 8) == 8'hFF, "R10",
              "abort ones", rx_bits.size() >= 16 ? bits_byte(rx_bits.size() - 8) : 0, 8'hFF);
        #1;
        check(in_ready == 1'b1, "R10", "ready while draining", in_ready, 1);
        @(negedge clk);
        rx_bits.delete();
        start = frames_done;
        info = '{8'h56, 8'h78, 8'h9A};
        drive(info, 1'b1, fires);
        repeat (20) @(negedge clk);
        check(rx_bits.size() == 0 && frames_done == start, "R10", "silent drain",
              rx_bits.size(), 0);
        #1;
        check(in_ready == 1'b0, "R10", "idle after drain", in_ready, 0);
        @(negedge clk);
        info = '{8'hDE, 8'hAD};
        run_frame(0, 0, 0, 8'h44, 8'h55, info, "R10", got);

        // random frames
        for (int n = 0; n < 40; n++) begin
            int len;
            logic [7:0] a, c;
            nc = $urandom % 2; na = $urandom % 2; nf = $urandom % 2;
            a = $urandom; c = $urandom;
            len = 1 + $urandom % 12;
            info.delete();
            for (int k = 0; k < len; k++) begin
                case ($urandom % 4)
                    0: info.push_back(8'hFF);
                    1: info.push_back(8'h7E);
                    2: info.push_back(8'hF8);
                    default: info.push_back(8'($urandom));
                endcase
            end
            if (nf) req = "R6";
            else if (na && nc) req = "R5";
            else if (nc) req = "R4";
            else req = "R3";
            run_frame(nc, na, nf, a, c, info, req, got);
        end

        check(idle_bad == 0, "R1", "line high when inactive", idle_bad, 0);
        finish_up();
    end
endmodule